// File: doc/BRIEF.md
# PLL Automatic Holdover Controller

This block is the digital supervisor that keeps a phase-locked loop's oscillator close to its last frequency when the loop loses lock. It contains a digital lock qualifier that watches phase comparisons at the phase detector. A comparison is reported by a feedback-edge strobe together with a flag that says whether the two edges fell inside the lock window. When a locked loop sees an out-of-window comparison, the controller can request that the charge pump go to high impedance. It does so only if the lock-detect pin level was high just before the loss. While that request is held, the dividers keep counting.

The high-impedance request ends on the next reference-path edge from the phase detector. In the cycle the request drops, the controller sends a one-cycle synchronous reset to the feedback divider's B counter so that the two divider outputs start out aligned. The prescaler is not reset. Holdover cannot be entered again until the qualifier reports lock and the lock pin has come back high. A configuration input can make the controller treat the pin as always high. Clearing the enable returns the controller to its idle state. Because the block acts on whatever reference edges it is given, a lock loss during a reference switchover produces only a short holdover that ends at the next edge.

Top module: `pll_holdover_ctrl`

## Requirements
- R1: While reset is asserted, state_o reads 0 (idle), and cp_hiz_o, fb_cnt_rst_o and dld_o are all 0.
- R2: With enable_i low, state_o becomes 0 and cp_hiz_o becomes 0 one clock later, whatever the state was. One clock after enable_i rises from idle, state_o reads 3 (reacquire).
- R3: dld_o rises on the clock edge of the N-th consecutive fb_edge_i strobe that has in_window_i high. A strobe with in_window_i low clears the run and drives dld_o low on that edge. Cycles without a strobe leave both unchanged.
- R4: N is lock_delay_i when that value is 5 or more. Any value below 5 gives N = 5.
- R5: In state 1 (armed), the effective pin level is the one registered on the previous clock. If an out-of-window strobe arrives while dld_o is high and that registered level is high, the next state is 2 (holdover) with cp_hiz_o = 1. If the registered level is low, the state stays 1 and cp_hiz_o stays 0.
- R6: When use_pin_i is 0, the effective pin level is 1 regardless of ld_pin_i. When use_pin_i is 1, the effective pin level is ld_pin_i.
- R7: In state 2, the state and cp_hiz_o = 1 are held on every clock without a ref_edge_i strobe, even while fb_edge_i strobes continue to advance the lock run.
- R8: One clock after a ref_edge_i strobe in state 2, state_o reads 3, cp_hiz_o is 0 and fb_cnt_rst_o is 1. fb_cnt_rst_o is 1 for only that clock and is never 1 on any other clock.
- R9: State 3 moves to state 1 only on a clock where dld_o is high and the registered effective pin level is high. A lock loss in state 3 never sets cp_hiz_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Holdover function enable |
| use_pin_i | input | 1 | 1: use ld_pin_i; 0: treat pin as high |
| ld_pin_i | input | 1 | Lock-detect pin level |
| fb_edge_i | input | 1 | One-cycle strobe per phase comparison (feedback edge) |
| in_window_i | input | 1 | Comparison inside the lock window, valid with fb_edge_i |
| ref_edge_i | input | 1 | One-cycle strobe per reference-path edge at the phase detector |
| lock_delay_i | input | 8 | Consecutive in-window comparisons needed for lock |
| cp_hiz_o | output | 1 | Charge-pump high-impedance request |
| fb_cnt_rst_o | output | 1 | Synchronous B-counter reset pulse |
| state_o | output | 2 | 0 idle, 1 armed, 2 holdover, 3 reacquire |
| dld_o | output | 1 | Qualified digital lock indication |

## Verification
The hardest case to reach is a loss of lock while the controller is in reacquire with the digital lock already high. To get there, the lock qualifier has to finish its count while the registered pin level is held low, so the controller cannot re-arm. The stimulus then toggles the enable to return to reacquire while the qualifier is still locked, and follows with an out-of-window strobe. A second hard case is holding holdover through a full lock run that completes before any reference edge arrives. The directed tests cover it by feeding eight in-window strobes after raising the lock delay, then checking that the high-impedance request stays asserted until the reference strobe.

// File: rtl/hov_pkg.sv
package hov_pkg;

  typedef enum logic [1:0] {
    HOV_OFF   = 2'd0,
    HOV_ARMED = 2'd1,
    HOV_HOLD  = 2'd2,
    HOV_REACQ = 2'd3
  } hov_state_e;

  // Number of in-window comparisons required, with a lower floor.
  function automatic int unsigned lock_target(input int unsigned req,
                                              input int unsigned floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

  // Lock pin level as seen by the holdover logic.
  function automatic logic pin_effective(input logic use_pin, input logic pin);
    return use_pin ? pin : 1'b1;
  endfunction

endpackage

// File: rtl/hov_lock_qualifier.sv
module hov_lock_qualifier #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned MIN_DELAY = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_stb,
  input  logic             in_win,
  input  logic [CNT_W-1:0] delay,
  output logic             locked,
  output logic             lock_lost
);
  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] run_q;
  logic             locked_q;
  logic             reach;

  assign target = CNT_W'(hov_pkg::lock_target(32'(delay), MIN_DELAY));
  assign reach  = (({1'b0, run_q} + ONE) >= {1'b0, target});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= '0;
      locked_q <= 1'b0;
    end else if (cmp_stb) begin
      if (!in_win) begin
        run_q    <= '0;
        locked_q <= 1'b0;
      end else begin
        if (run_q < target) run_q <= run_q + 1'b1;
        if (reach) locked_q <= 1'b1;
      end
    end
  end

  assign locked    = locked_q;
  assign lock_lost = cmp_stb & ~in_win & locked_q;

endmodule

// File: rtl/hov_pin_sampler.sv
module hov_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic use_pin,
  input  logic pin,
  output logic pin_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= hov_pkg::pin_effective(use_pin, pin);
  end
endmodule

// File: rtl/hov_fsm.sv
module hov_fsm
  import hov_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       lock_lost,
  input  logic       locked,
  input  logic       pin_q,
  input  logic       ref_stb,
  output hov_state_e state,
  output logic       hiz,
  output logic       b_rst
);
  hov_state_e state_q, state_d;
  logic       b_rst_q;
  logic       release_evt;

  assign release_evt = en & (state_q == HOV_HOLD) & ref_stb;

  always_comb begin
    state_d = state_q;
    if (!en) begin
      state_d = HOV_OFF;
    end else begin
      unique case (state_q)
        HOV_OFF:   state_d = HOV_REACQ;
        HOV_ARMED: if (lock_lost && pin_q) state_d = HOV_HOLD;
        HOV_HOLD:  if (ref_stb) state_d = HOV_REACQ;
        HOV_REACQ: if (locked && pin_q) state_d = HOV_ARMED;
        default:   state_d = HOV_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HOV_OFF;
      b_rst_q <= 1'b0;
    end else begin
      state_q <= state_d;
      b_rst_q <= release_evt;
    end
  end

  assign state = state_q;
  assign hiz   = (state_q == HOV_HOLD);
  assign b_rst = b_rst_q;

endmodule

// File: rtl/pll_holdover_ctrl.sv
module pll_holdover_ctrl
  import hov_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned MIN_DELAY = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             use_pin_i,
  input  logic             ld_pin_i,
  input  logic             fb_edge_i,
  input  logic             in_window_i,
  input  logic             ref_edge_i,
  input  logic [CNT_W-1:0] lock_delay_i,
  output logic             cp_hiz_o,
  output logic             fb_cnt_rst_o,
  output logic [1:0]       state_o,
  output logic             dld_o
);
  logic       locked_w;
  logic       lock_lost_w;
  logic       pin_q_w;
  hov_state_e state_w;

  hov_lock_qualifier #(.CNT_W(CNT_W), .MIN_DELAY(MIN_DELAY)) u_qual (
    .clk(clk_i), .rst_n(rst_ni), .cmp_stb(fb_edge_i), .in_win(in_window_i),
    .delay(lock_delay_i), .locked(locked_w), .lock_lost(lock_lost_w)
  );

  hov_pin_sampler u_pin (
    .clk(clk_i), .rst_n(rst_ni), .use_pin(use_pin_i), .pin(ld_pin_i),
    .pin_q(pin_q_w)
  );

  hov_fsm u_fsm (
    .clk(clk_i), .rst_n(rst_ni), .en(enable_i), .lock_lost(lock_lost_w),
    .locked(locked_w), .pin_q(pin_q_w), .ref_stb(ref_edge_i),
    .state(state_w), .hiz(cp_hiz_o), .b_rst(fb_cnt_rst_o)
  );

  assign state_o = state_w;
  assign dld_o   = locked_w;

endmodule

// File: rtl/hov_checker.sv
module hov_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       fb,
  input logic       win,
  input logic       ref_e,
  input logic [1:0] state,
  input logic       hiz,
  input logic       brst,
  input logic       dld,
  input logic       lost,
  input logic       pin_q
);
  assert_disable_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state == 2'd0) && !hiz);

  assert_lock_rise_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dld) |-> $past(fb && win));

  assert_no_entry_pin_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == 2'd1 && lost && !pin_q) |=> (state == 2'd1) && !hiz);

  assert_hold_persists_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == 2'd2 && !ref_e) |=> (state == 2'd2) && hiz);

  assert_reset_pulse_on_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brst |-> (state == 2'd3) && !hiz && $past(state == 2'd2) && $past(ref_e));

  assert_reacq_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == 2'd3 && !(dld && pin_q)) |=> (state == 2'd3) && !hiz);
endmodule

bind pll_holdover_ctrl hov_checker u_hov_chk (
  .clk(clk_i), .rst_n(rst_ni), .en(enable_i), .fb(fb_edge_i), .win(in_window_i),
  .ref_e(ref_edge_i), .state(state_o), .hiz(cp_hiz_o), .brst(fb_cnt_rst_o),
  .dld(dld_o), .lost(lock_lost_w), .pin_q(pin_q_w)
);

// File: tb/test_pll_holdover_ctrl.sv
`timescale 1ns/1ps
module test_pll_holdover_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, use_pin = 0, pin = 0, fb = 0, win = 0, ref_e = 0;
  logic [7:0] delay = 8'd5;
  logic hiz, brst, dld;
  logic [1:0] st;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pll_holdover_ctrl i_pll_holdover_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .use_pin_i(use_pin),
    .ld_pin_i(pin), .fb_edge_i(fb), .in_window_i(win), .ref_edge_i(ref_e),
    .lock_delay_i(delay), .cp_hiz_o(hiz), .fb_cnt_rst_o(brst),
    .state_o(st), .dld_o(dld)
  );

  // {en,use,pin,fb,win,ref, state[1:0], hiz, brst, dld}
  localparam logic [10:0] VEC [0:19] = '{
    11'b1_1_1_0_0_0_11_0_0_0,  // v0  enable -> reacquire
    11'b1_1_1_1_1_0_11_0_0_0,  // v1  run 1
    11'b1_1_1_1_1_0_11_0_0_0,  // v2
    11'b1_1_1_1_1_0_11_0_0_0,  // v3
    11'b1_1_1_1_1_0_11_0_0_0,  // v4
    11'b1_1_1_1_1_0_11_0_0_1,  // v5  fifth in-window -> lock
    11'b1_1_1_0_0_0_01_0_0_1,  // v6  armed
    11'b1_1_1_1_0_0_10_1_0_0,  // v7  loss with pin high -> holdover
    11'b1_1_0_0_0_0_10_1_0_0,  // v8  hold
    11'b1_1_0_1_1_0_10_1_0_0,  // v9  hold while counting
    11'b1_1_0_0_0_1_11_0_1_0,  // v10 ref edge -> release, B reset
    11'b1_1_0_1_1_0_11_0_0_0,  // v11 pulse gone
    11'b1_1_0_1_1_0_11_0_0_0,  // v12
    11'b1_1_0_1_1_0_11_0_0_0,  // v13
    11'b1_1_0_1_1_0_11_0_0_1,  // v14 lock again
    11'b1_1_0_0_0_0_11_0_0_1,  // v15 pin low blocks rearm
    11'b1_1_1_0_0_0_11_0_0_1,  // v16 pin sampled this edge
    11'b1_1_1_0_0_0_01_0_0_1,  // v17 armed
    11'b1_1_0_0_0_0_01_0_0_1,  // v18 pin drops
    11'b1_1_0_1_0_0_01_0_0_0   // v19 loss with pin low -> stay armed
  };

  function automatic string vec_req(input int i);
    case (i)
      0:  return "R2";
      1, 2, 3, 4, 5, 12, 13, 14: return "R3";
      6, 15, 16, 17, 18: return "R9";
      7, 19: return "R5";
      8, 9: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp_v);
    end
  endtask

  task automatic drive(input logic e, input logic u, input logic p,
                       input logic f, input logic w, input logic r);
    @(negedge clk);
    en = e; use_pin = u; pin = p; fb = f; win = w; ref_e = r;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [4:0] outs();
    return {st, hiz, brst, dld};
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", outs(), 5'b00_0_0_0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 20; i++) begin
      drive(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5]);
      chk($sformatf("%s vector %0d", vec_req(i), i), outs(), VEC[i][4:0]);
    end

    // R6: pin ignored when use_pin=0 (pin held low)
    for (int k = 0; k < 5; k++) drive(1, 0, 0, 1, 1, 0);
    chk("R6 lock with pin ignored", outs(), 5'b01_0_0_1);
    drive(1, 0, 0, 1, 0, 0);
    chk("R6 loss enters holdover", outs(), 5'b10_1_0_0);

    // R2: disable from holdover
    drive(0, 0, 0, 0, 0, 0);
    chk("R2 disable clears", outs(), 5'b00_0_0_0);
    drive(1, 0, 0, 0, 0, 0);
    chk("R2 enable to reacquire", outs(), 5'b11_0_0_0);

    // R4: delay 2 clamps to 5
    delay = 8'd2;
    for (int k = 0; k < 4; k++) drive(1, 0, 0, 1, 1, 0);
    chk("R4 clamp four strobes", outs(), 5'b11_0_0_0);
    drive(1, 0, 0, 1, 1, 0);
    chk("R4 clamp fifth strobe", outs(), 5'b11_0_0_1);
    drive(1, 0, 0, 0, 0, 0);
    chk("R9 rearm with pin ignored", outs(), 5'b01_0_0_1);

    // R3/R7: delay 8, holdover persists through a full run
    delay = 8'd8;
    drive(1, 0, 0, 1, 0, 0);
    chk("R5 holdover entry", outs(), 5'b10_1_0_0);
    for (int k = 0; k < 7; k++) drive(1, 0, 0, 1, 1, 0);
    chk("R3 seven of eight", outs(), 5'b10_1_0_0);
    drive(1, 0, 0, 1, 1, 0);
    chk("R7 hold after lock", outs(), 5'b10_1_0_1);
    drive(1, 0, 0, 0, 0, 1);
    chk("R8 release pulse", outs(), 5'b11_0_1_1);
    drive(1, 0, 0, 0, 0, 0);
    chk("R8 pulse one cycle", outs(), 5'b01_0_0_1);

    // R9: loss in reacquire with dld high, pin low
    drive(0, 1, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 0, 0);
    chk("R9 blocked by pin", outs(), 5'b11_0_0_1);
    drive(1, 1, 0, 1, 0, 0);
    chk("R9 loss in reacquire", outs(), 5'b11_0_0_0);
    drive(1, 1, 0, 0, 0, 1);
    chk("R8 no pulse outside holdover", outs(), 5'b11_0_0_0);

    // R1: reset mid-run
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R1 reset mid-run", outs(), 5'b00_0_0_0);

    done = 1;
    finish_run();
  end
endmodule